// File: doc/BRIEF.md
# Sleep Mode Sequencer

This block sequences a microcontroller through its two sleep modes. A one-cycle deep-sleep request from the core turns the oscillator enable off. A one-cycle light-sleep request turns off only the processor clock enable, and the oscillator keeps running. Entering either mode sends a one-cycle strobe that clears the processor's interrupt mask. A second one-cycle strobe, in the same cycle, sets the external-interrupt enable bit. No other control state is touched.

Each mode has its own set of wake sources. Light sleep wakes on any interrupt source: the two external interrupts, the bus-resume event, the general timer and the second timer. Deep sleep ignores both timers, because the timers are not clocked in deep sleep. The three reset sources (external pin, bus reset, low-voltage reset) end any sleep state at once. When deep sleep ends on an interrupt, the processor clock stays gated for a stabilization wait of 128 or 4064 cycles, chosen by a static option pin.

The whole sequencer runs on a free-running wake clock, which is still present while the main oscillator is stopped.

Top module: `sleep_seq_top`

## Requirements
- R1: While reset is active and after it, the state is RUN, `oscEn` and `cpuClkEn` are 1, and `maskClr`, `irqEnSet`, `wakeIrq` and `wakeRst` are 0.
- R2: In RUN, a `stopReq` pulse moves the state to STOP on the next clock edge. In STOP, `oscEn` is 0 and `cpuClkEn` is 0.
- R3: In RUN, a `waitReq` pulse (with `stopReq` low) moves the state to WAIT on the next edge. In WAIT, `oscEn` is 1 and `cpuClkEn` is 0.
- R4: Entering STOP or WAIT raises `maskClr` and `irqEnSet` together for exactly the first cycle in the new state. If `stopReq` and `waitReq` arrive together, STOP is chosen.
- R5: In STOP, a pulse on `extIrqA`, `extIrqB` or `busResume` moves the state to STABILIZE on the next edge and raises `wakeIrq` for that one cycle.
- R6: In STOP, `timerIrq` and `timer2Irq` are ignored: the state stays STOP and `wakeIrq` stays 0.
- R7: In WAIT, a pulse on any of `extIrqA`, `extIrqB`, `busResume`, `timerIrq` or `timer2Irq` returns the state to RUN on the next edge, with a one-cycle `wakeIrq`.
- R8: The state stays in STABILIZE for exactly N cycles and then goes to RUN. N is 128 when `longDelay` is 0 and 4064 when it is 1. The count starts again from zero on every deep-sleep entry.
- R9: In WAIT, STOP or STABILIZE, a pulse on `extRst`, `busRst` or `lvRst` returns the state to RUN on the next edge, raises `wakeRst` for one cycle and leaves `wakeIrq` at 0. A reset source outranks a concurrent interrupt.
- R10: `stopReq` and `waitReq` are ignored in any state other than RUN.
- R11: `sleepState` reports the state as RUN=2'b00, WAIT=2'b01, STOP=2'b10, STABILIZE=2'b11.
- R12: In RUN, wake and reset inputs have no effect: the state stays RUN and all four strobes stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running wake clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReq | input | 1 | Deep-sleep request pulse |
| waitReq | input | 1 | Light-sleep request pulse |
| extIrqA | input | 1 | First external interrupt |
| extIrqB | input | 1 | Second external interrupt |
| busResume | input | 1 | Bus activity resume event |
| timerIrq | input | 1 | General timer interrupt |
| timer2Irq | input | 1 | Second timer interrupt |
| extRst | input | 1 | External reset wake |
| busRst | input | 1 | Bus reset wake |
| lvRst | input | 1 | Low-voltage reset wake |
| longDelay | input | 1 | Stabilization select: 0 gives 128 cycles, 1 gives 4064 cycles |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | Processor clock enable |
| maskClr | output | 1 | Interrupt-mask clear strobe |
| irqEnSet | output | 1 | External-interrupt enable set strobe |
| wakeIrq | output | 1 | Woken by an interrupt source |
| wakeRst | output | 1 | Woken by a reset source |
| sleepState | output | 2 | Current state code |

## Verification
Some properties are checked on every cycle by assertions:
- a request taken in RUN leads to the right sleep state, and a request arriving in another state leaves that state unchanged;
- timers cannot disturb deep sleep;
- any reset source brings the state back to RUN;
- the counter is at zero throughout deep sleep;
- the entry strobes always fire together and last one cycle.

Other behaviour only the directed scenarios can show:
- the exact length of the stabilization wait for each option setting;
- the clock-enable levels in each state;
- the separation between interrupt wakes and reset wakes;
- the fact that inputs have no effect in RUN.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_WAIT = 2'b01,
    ST_STOP = 2'b10,
    ST_STAB = 2'b11
  } slpState_e;

  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic entry;
    logic irqExit;
    logic rstExit;
  } ctlStrobe_t;

endpackage

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopReq,
  input  logic       waitReq,
  input  logic       extIrqA,
  input  logic       extIrqB,
  input  logic       busResume,
  input  logic       timerIrq,
  input  logic       timer2Irq,
  input  logic       extRst,
  input  logic       busRst,
  input  logic       lvRst,
  input  logic       cntDone,
  output slpState_e  state,
  output ctlStrobe_t strobe
);

  logic      deepWake;
  logic      lightWake;
  logic      anyRst;
  slpState_e nextState;

  assign deepWake  = extIrqA | extIrqB | busResume;
  assign lightWake = deepWake | timerIrq | timer2Irq;
  assign anyRst    = extRst | busRst | lvRst;

  always_comb begin
    nextState      = state;
    strobe         = '0;
    strobe.cntEn   = (state == ST_STAB);
    strobe.cntClr  = (state != ST_STAB);
    unique case (state)
      ST_RUN: begin
        if (stopReq) begin
          nextState    = ST_STOP;
          strobe.entry = 1'b1;
        end else if (waitReq) begin
          nextState    = ST_WAIT;
          strobe.entry = 1'b1;
        end
      end
      ST_WAIT: begin
        if (anyRst) begin
          nextState      = ST_RUN;
          strobe.rstExit = 1'b1;
        end else if (lightWake) begin
          nextState      = ST_RUN;
          strobe.irqExit = 1'b1;
        end
      end
      ST_STOP: begin
        if (anyRst) begin
          nextState      = ST_RUN;
          strobe.rstExit = 1'b1;
        end else if (deepWake) begin
          nextState      = ST_STAB;
          strobe.irqExit = 1'b1;
        end
      end
      ST_STAB: begin
        if (anyRst) begin
          nextState      = ST_RUN;
          strobe.rstExit = 1'b1;
        end else if (cntDone) begin
          nextState      = ST_RUN;
        end
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  // R2: a deep-sleep request taken in RUN lands in STOP
  a_r2_stop_entry: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && stopReq) |=> (state == ST_STOP));

  // R6: timers alone do not disturb deep sleep
  a_r6_timer_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && !deepWake && !anyRst) |=> (state == ST_STOP));

  // R9: any reset source returns to RUN from a sleep state
  a_r9_rst_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_RUN && anyRst) |=> (state == ST_RUN));

  // R10: requests outside RUN are ignored
  a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !lightWake && !anyRst) |=> (state == ST_WAIT));

  // R8: a finished count releases STABILIZE
  a_r8_done_exits: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STAB && cntDone && !anyRst) |=> (state == ST_RUN));

endmodule

// File: rtl/sleep_seq_dpath.sv
module sleep_seq_dpath
  import sleep_seq_pkg::*;
#(
  parameter int SHORT_DLY = 128,
  parameter int LONG_DLY  = 4064
) (
  input  logic       clk,
  input  logic       rstN,
  input  slpState_e  state,
  input  ctlStrobe_t strobe,
  input  logic       longDelay,
  output logic       cntDone,
  output logic       oscEn,
  output logic       cpuClkEn,
  output logic       maskClr,
  output logic       irqEnSet,
  output logic       wakeIrq,
  output logic       wakeRst
);

  localparam int MAX_DLY = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_DLY - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_DLY - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntEn)  cnt <= cnt + 1'b1;
  end

  assign cntDone = (cnt == (longDelay ? LONG_LAST : SHORT_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskClr  <= 1'b0;
      irqEnSet <= 1'b0;
      wakeIrq  <= 1'b0;
      wakeRst  <= 1'b0;
    end else begin
      maskClr  <= strobe.entry;
      irqEnSet <= strobe.entry;
      wakeIrq  <= strobe.irqExit;
      wakeRst  <= strobe.rstExit;
    end
  end

  assign oscEn    = (state != ST_STOP);
  assign cpuClkEn = (state == ST_RUN);

  // R8: counter sits at zero throughout deep sleep
  a_r8_cnt_zero_in_stop: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP) |-> (cnt == '0));

  // R4: entry strobes fire together for a single cycle
  a_r4_strobes_paired: assert property (@(posedge clk) disable iff (!rstN)
    maskClr |-> (irqEnSet && (state == ST_STOP || state == ST_WAIT)));

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    maskClr |=> !maskClr);

  // R9: reset wake never reports as an interrupt wake
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(wakeIrq && wakeRst));

endmodule

// File: rtl/sleep_seq_top.sv
module sleep_seq_top
  import sleep_seq_pkg::*;
#(
  parameter int SHORT_DLY = 128,
  parameter int LONG_DLY  = 4064
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopReq,
  input  logic       waitReq,
  input  logic       extIrqA,
  input  logic       extIrqB,
  input  logic       busResume,
  input  logic       timerIrq,
  input  logic       timer2Irq,
  input  logic       extRst,
  input  logic       busRst,
  input  logic       lvRst,
  input  logic       longDelay,
  output logic       oscEn,
  output logic       cpuClkEn,
  output logic       maskClr,
  output logic       irqEnSet,
  output logic       wakeIrq,
  output logic       wakeRst,
  output logic [1:0] sleepState
);

  slpState_e  state;
  ctlStrobe_t strobe;
  logic       cntDone;

  sleep_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .waitReq(waitReq),
    .extIrqA(extIrqA), .extIrqB(extIrqB), .busResume(busResume),
    .timerIrq(timerIrq), .timer2Irq(timer2Irq), .extRst(extRst),
    .busRst(busRst), .lvRst(lvRst), .cntDone(cntDone),
    .state(state), .strobe(strobe)
  );

  sleep_seq_dpath #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) dpath_i (
    .clk(clk), .rstN(rstN), .state(state), .strobe(strobe),
    .longDelay(longDelay), .cntDone(cntDone), .oscEn(oscEn),
    .cpuClkEn(cpuClkEn), .maskClr(maskClr), .irqEnSet(irqEnSet),
    .wakeIrq(wakeIrq), .wakeRst(wakeRst)
  );

  assign sleepState = state;

endmodule

// File: tb/sleep_seq_top_tb_top.sv
module sleep_seq_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 0, waitReq = 0, extIrqA = 0, extIrqB = 0, busResume = 0;
  logic timerIrq = 0, timer2Irq = 0, extRst = 0, busRst = 0, lvRst = 0;
  logic longDelay = 0;
  logic oscEn, cpuClkEn, maskClr, irqEnSet, wakeIrq, wakeRst;
  logic [1:0] sleepState;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  localparam logic [1:0] S_RUN = 2'b00, S_WAIT = 2'b01, S_STOP = 2'b10, S_STAB = 2'b11;

  always #5 clk = ~clk;

  sleep_seq_top dut_i (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .waitReq(waitReq),
    .extIrqA(extIrqA), .extIrqB(extIrqB), .busResume(busResume),
    .timerIrq(timerIrq), .timer2Irq(timer2Irq), .extRst(extRst),
    .busRst(busRst), .lvRst(lvRst), .longDelay(longDelay),
    .oscEn(oscEn), .cpuClkEn(cpuClkEn), .maskClr(maskClr),
    .irqEnSet(irqEnSet), .wakeIrq(wakeIrq), .wakeRst(wakeRst),
    .sleepState(sleepState)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    {stopReq, waitReq, extIrqA, extIrqB, busResume} = '0;
    {timerIrq, timer2Irq, extRst, busRst, lvRst} = '0;
  endtask

  // index: 0 stop,1 wait,2 irqA,3 irqB,4 resume,5 tmr,6 tmr2,7 extRst,8 busRst,9 lvRst
  task automatic setIn(input int idx);
    case (idx)
      0: stopReq = 1;   1: waitReq = 1;   2: extIrqA = 1;   3: extIrqB = 1;
      4: busResume = 1; 5: timerIrq = 1;  6: timer2Irq = 1; 7: extRst = 1;
      8: busRst = 1;    default: lvRst = 1;
    endcase
  endtask

  // drive a one-cycle pulse, sample at the following falling edge
  task automatic pulse(input int idx);
    @(negedge clk); setIn(idx);
    @(negedge clk); clearIn();
  endtask

  task automatic tReset();
    #1;
    chk("R1 state in reset", sleepState, S_RUN);
    chk("R1 oscEn in reset", oscEn, 1);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    chk("R1 cpuClkEn", cpuClkEn, 1);
    chk("R1 strobes", {maskClr, irqEnSet, wakeIrq, wakeRst}, 0);
  endtask

  task automatic tRunIdle();
    for (int i = 2; i < 10; i++) begin
      pulse(i);
      chk("R12 state stays RUN", sleepState, S_RUN);
      chk("R12 strobes quiet", {maskClr, irqEnSet, wakeIrq, wakeRst}, 0);
    end
  endtask

  task automatic tWait(input int src);
    pulse(1);
    chk("R3 WAIT state R11", sleepState, S_WAIT);
    chk("R3 osc on", oscEn, 1);
    chk("R3 cpu clk off", cpuClkEn, 0);
    chk("R4 entry strobes", {maskClr, irqEnSet}, 3);
    @(negedge clk);
    chk("R4 strobe one cycle", {maskClr, irqEnSet}, 0);
    pulse(0);
    chk("R10 stopReq ignored in WAIT", sleepState, S_WAIT);
    chk("R10 no entry strobe", maskClr, 0);
    pulse(src);
    chk("R7 wake to RUN", sleepState, S_RUN);
    chk("R7 wakeIrq", wakeIrq, 1);
    @(negedge clk);
    chk("R7 wakeIrq one cycle", wakeIrq, 0);
  endtask

  task automatic tStop(input logic lng, input int src);
    int n;
    n = lng ? 4064 : 128;
    longDelay = lng;
    @(negedge clk); stopReq = 1; waitReq = 1;
    @(negedge clk); clearIn();
    chk("R4 stop wins over wait", sleepState, S_STOP);
    chk("R2 osc off", oscEn, 0);
    chk("R2 cpu clk off", cpuClkEn, 0);
    chk("R4 entry strobes stop", {maskClr, irqEnSet}, 3);
    pulse(5);
    chk("R6 timer ignored", sleepState, S_STOP);
    pulse(6);
    chk("R6 timer2 ignored", sleepState, S_STOP);
    chk("R6 no wakeIrq", wakeIrq, 0);
    pulse(src);
    chk("R5 to STABILIZE R11", sleepState, S_STAB);
    chk("R5 wakeIrq", wakeIrq, 1);
    chk("R8 osc on during wait", oscEn, 1);
    pulse(1);
    chk("R10 waitReq ignored in STABILIZE", sleepState, S_STAB);
    repeat (n - 3) @(negedge clk);
    chk("R8 still gated at N-1", cpuClkEn, 0);
    @(negedge clk);
    chk("R8 released after N", cpuClkEn, 1);
    chk("R8 state RUN", sleepState, S_RUN);
  endtask

  task automatic tRstExit(input int mode, input int src);
    pulse(mode);
    if (mode == 0) pulse(2);
    @(negedge clk); setIn(src); extIrqB = 1;
    @(negedge clk); clearIn();
    chk("R9 reset exit to RUN", sleepState, S_RUN);
    chk("R9 wakeRst", wakeRst, 1);
    chk("R9 no wakeIrq", wakeIrq, 0);
    @(negedge clk);
    chk("R9 wakeRst one cycle", wakeRst, 0);
  endtask

  initial begin
    tReset();
    tRunIdle();
    for (int s = 2; s < 7; s++) tWait(s);
    tStop(1'b0, 2);
    tStop(1'b0, 3);
    tStop(1'b0, 4);
    tStop(1'b1, 2);
    tStop(1'b0, 4);
    tRstExit(1, 7);
    tRstExit(1, 8);
    tRstExit(0, 9);
    tRstExit(0, 7);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule